// File: doc/BRIEF.md
# Page Permission Check and Reference/Change Recorder

This block takes one leaf translation entry, with the address it was read from, and decides whether a given access may use it. The inputs are the access kind (load, store or instruction fetch), whether the processor runs in user mode, whether the check is for the partition (host) stage rather than the process (guest) stage, and a three-bit mask of permissions that software allows supervisor code on non-privileged pages. The block returns a fault flag, a cause code and the read/write/execute permissions that the caller may cache for the page.

When the access is allowed, the block marks the entry as referenced, and as changed for a store. If that alters the entry, it writes the new value back through a single-beat request/acknowledge write port before it reports completion. After a load or fetch the write permission is dropped from the returned set. A later store to the same page therefore comes back through this block, and that pass sets the change bit.

The controller has four states: `ST_IDLE`, `ST_EVAL`, `ST_WRITE` and `ST_DONE`. Its transitions are:
- **accept**: `ST_IDLE` to `ST_EVAL` when `start_i` is high.
- **settle_clean**: `ST_EVAL` to `ST_DONE` on a fault or when the entry is unchanged.
- **settle_dirty**: `ST_EVAL` to `ST_WRITE` when a write-back is needed.
- **acked**: `ST_WRITE` to `ST_DONE` when `wr_ack_i` is high.
- **retire**: `ST_DONE` to `ST_IDLE`, always.

Entry layout:

| Bits | Meaning |
|------|---------|
| [2:0] | Access-authority bits: bit2 read, bit1 write, bit0 execute |
| [3] | Privileged-page bit |
| [5:4] | Attribute field; the value 2'b10 marks non-idempotent I/O |
| [7] | Change bit |
| [8] | Reference bit |

Permission vectors (`amr_perm_i`, `perm_o`) use the same read/write/execute bit order as the authority bits.

Top module: `pte_prot_rc`

## Requirements
- R1: An instruction fetch (`access_i`=2'b10) of an entry whose attribute field [5:4] equals 2'b10 faults with cause bit0 set (guard fault). A load or store of the same entry is checked by the normal permission rules.
- R2: In process scope (`part_scope_i`=0), when the entry's privileged bit [3] is set and `user_i`=1, nothing is granted, so every access faults with cause bit1 set.
- R3: For a user access, a privileged page or a partition-scope check, the granted set is the entry's bits [2:0] alone, and `amr_perm_i` has no effect.
- R4: For a supervisor access in process scope to a non-privileged page, the granted set is bits [2:0] ANDed with `amr_perm_i`.
- R5: Each access kind needs one permission: a load (2'b00) needs read, a store (2'b01) needs write, a fetch (2'b10) needs execute, and code 2'b11 is checked as a load. If that permission is not granted, the access faults with cause bit1 (protection fault).
- R6: On success the written entry is the original with bit8 (reference) set, and with bit7 (change) also set for a store.
- R7: On success, `perm_o` is the granted set with the write bit cleared for any access other than a store. For a store it is the granted set unchanged.
- R8: A write to `wr_addr_i`=`pte_addr_i` is issued only on success, and only when the updated entry differs from the original. Otherwise no write takes place.
- R9: `wr_req_o` stays high, with address and data stable, until `wr_ack_i` is sampled high. `done_o` follows at the next edge. Without a write, `done_o` rises at the first edge after the edge that accepts `start_i`.
- R10: `done_o` is high for exactly one cycle. `fault_o`, `cause_o` and `perm_o` hold their values until the next accepted start. After reset, `busy_o`, `done_o` and `wr_req_o` are low.
- R11: `start_i` is ignored while `busy_o` is high. The check in progress keeps its captured inputs, and no second check follows.
- R12: On a fault, `perm_o` is 0, at most one cause bit is set and no write is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a check; inputs are captured when accepted |
| pte_i | input | PTE_W | Leaf entry to check |
| pte_addr_i | input | ADDR_W | Memory address of the entry |
| access_i | input | 2 | 00 load, 01 store, 10 fetch, 11 treated as load |
| user_i | input | 1 | Processor in user mode |
| part_scope_i | input | 1 | Partition-stage check |
| amr_perm_i | input | 3 | Supervisor permission mask (read, write, execute) |
| busy_o | output | 1 | Check in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Access denied |
| cause_o | output | 2 | bit0 guard fault, bit1 protection fault |
| perm_o | output | 3 | Permissions returned to the caller |
| wr_req_o | output | 1 | Write-back request |
| wr_addr_o | output | ADDR_W | Write-back address |
| wr_data_o | output | PTE_W | Updated entry |
| wr_ack_i | input | 1 | Write-back accepted |

## Verification
The permission logic is tried with the same entries under different scopes, modes and masks. One case is a privileged page seen from user mode, in process scope and then in partition scope, which separates R2 from R3. Another is a supervisor access to a non-privileged page under masks that do and do not cover the needed bit, which shows that the mask applies only in that one case.

Entries that already carry reference, or reference and change, show whether the write is correctly skipped. A slow acknowledge and a start pulse that arrives during a write show whether the handshake holds its data and ignores new requests.

A fetch and a load of the same I/O-marked entry separate the guard rule from the protection rule. The reserved access code shows that it is checked as a load.

// File: rtl/pte_prot_pkg.sv
package pte_prot_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_WRITE,
        ST_DONE
    } state_e;

    // Field positions inside a leaf entry
    localparam int unsigned AUTH_LSB  = 0;
    localparam int unsigned AUTH_W    = 3;
    localparam int unsigned PRIV_BIT  = 3;
    localparam int unsigned ATTR_LSB  = 4;
    localparam int unsigned ATTR_W    = 2;
    localparam int unsigned CHG_BIT   = 7;
    localparam int unsigned REF_BIT   = 8;
    localparam logic [ATTR_W-1:0] ATTR_NONIDEM_IO = 2'b10;

    // Permission vector bit order
    localparam int unsigned PERM_X = 0;
    localparam int unsigned PERM_W = 1;
    localparam int unsigned PERM_R = 2;
    localparam int unsigned PERM_N = 3;

    // Cause vector bit order
    localparam int unsigned CAUSE_GUARD = 0;
    localparam int unsigned CAUSE_PROT  = 1;
    localparam int unsigned CAUSE_N     = 2;

endpackage

// File: rtl/pte_prot_authority.sv
module pte_prot_authority
    import pte_prot_pkg::*;
(
    input  logic [PERM_N-1:0] auth_i,
    input  logic              priv_page_i,
    input  logic              user_i,
    input  logic              part_scope_i,
    input  logic [PERM_N-1:0] amr_i,
    output logic [PERM_N-1:0] grant_o
);

    logic user_locked;
    logic mask_applies;

    always_comb begin
        user_locked  = !part_scope_i && priv_page_i && user_i;
        mask_applies = !part_scope_i && !priv_page_i && !user_i;
        unique case ({user_locked, mask_applies})
            2'b10:   grant_o = '0;
            2'b01:   grant_o = auth_i & amr_i;
            default: grant_o = auth_i;
        endcase
    end

endmodule

// File: rtl/pte_prot_verdict.sv
module pte_prot_verdict
    import pte_prot_pkg::*;
(
    input  logic [ATTR_W-1:0] attr_i,
    input  acc_e              acc_i,
    input  logic [PERM_N-1:0] grant_i,
    output logic              guard_o,
    output logic              prot_o
);

    logic [PERM_N-1:0] need;
    logic [PERM_N-1:0] miss;

    always_comb begin
        need = '0;
        unique case (acc_i)
            ACC_STORE: need[PERM_W] = 1'b1;
            ACC_FETCH: need[PERM_X] = 1'b1;
            default:   need[PERM_R] = 1'b1;
        endcase
    end

    for (genvar b = 0; b < PERM_N; b++) begin : g_miss
        assign miss[b] = need[b] & ~grant_i[b];
    end

    assign guard_o = (attr_i == ATTR_NONIDEM_IO) && (acc_i == ACC_FETCH);
    assign prot_o  = !guard_o && (|miss);

endmodule

// File: rtl/pte_prot_rc_merge.sv
module pte_prot_rc_merge
    import pte_prot_pkg::*;
#(
    parameter int unsigned PTE_W = 64
)(
    input  logic [PTE_W-1:0]  pte_i,
    input  logic              is_store_i,
    input  logic              fault_i,
    input  logic [PERM_N-1:0] grant_i,
    output logic [PTE_W-1:0]  pte_o,
    output logic              dirty_o,
    output logic [PERM_N-1:0] perm_o
);

    always_comb begin
        pte_o          = pte_i;
        pte_o[REF_BIT] = 1'b1;
        if (is_store_i) begin
            pte_o[CHG_BIT] = 1'b1;
        end
        dirty_o = !fault_i && (pte_o != pte_i);

        perm_o = grant_i;
        if (!is_store_i) begin
            perm_o[PERM_W] = 1'b0;
        end
        if (fault_i) begin
            perm_o = '0;
        end
    end

endmodule

// File: rtl/pte_prot_rc.sv
module pte_prot_rc
    import pte_prot_pkg::*;
#(
    parameter int unsigned PTE_W  = 64,
    parameter int unsigned ADDR_W = 56
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [PTE_W-1:0]    pte_i,
    input  logic [ADDR_W-1:0]   pte_addr_i,
    input  logic [1:0]          access_i,
    input  logic                user_i,
    input  logic                part_scope_i,
    input  logic [2:0]          amr_perm_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                fault_o,
    output logic [1:0]          cause_o,
    output logic [2:0]          perm_o,
    output logic                wr_req_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [PTE_W-1:0]    wr_data_o,
    input  logic                wr_ack_i
);

    localparam int unsigned MIN_PTE_W = REF_BIT + 1;

    if (PTE_W < MIN_PTE_W) begin : g_bad_width
        initial $error("PTE_W too small for the entry layout");
    end

    state_e state_q, state_d;

    // Captured request
    logic [PTE_W-1:0]  pte_q;
    logic [ADDR_W-1:0] addr_q;
    acc_e              acc_q;
    logic              user_q;
    logic              part_q;
    logic [PERM_N-1:0] amr_q;

    // Registered results
    logic              fault_q;
    logic [CAUSE_N-1:0] cause_q;
    logic [PERM_N-1:0] perm_q;
    logic [PTE_W-1:0]  wdata_q;

    // Evaluation network
    logic [PERM_N-1:0] grant;
    logic              guard;
    logic              prot;
    logic              fault_now;
    logic [PTE_W-1:0]  next_pte;
    logic              dirty;
    logic [PERM_N-1:0] perm_now;

    pte_prot_authority u_auth (
        .auth_i       (pte_q[AUTH_LSB +: AUTH_W]),
        .priv_page_i  (pte_q[PRIV_BIT]),
        .user_i       (user_q),
        .part_scope_i (part_q),
        .amr_i        (amr_q),
        .grant_o      (grant)
    );

    pte_prot_verdict u_verdict (
        .attr_i  (pte_q[ATTR_LSB +: ATTR_W]),
        .acc_i   (acc_q),
        .grant_i (grant),
        .guard_o (guard),
        .prot_o  (prot)
    );

    assign fault_now = guard | prot;

    pte_prot_rc_merge #(.PTE_W(PTE_W)) u_merge (
        .pte_i      (pte_q),
        .is_store_i (acc_q == ACC_STORE),
        .fault_i    (fault_now),
        .grant_i    (grant),
        .pte_o      (next_pte),
        .dirty_o    (dirty),
        .perm_o     (perm_now)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_EVAL;           // accept
            ST_EVAL:  state_d = dirty ? ST_WRITE : ST_DONE;      // settle_dirty / settle_clean
            ST_WRITE: if (wr_ack_i) state_d = ST_DONE;           // acked
            ST_DONE:  state_d = ST_IDLE;                         // retire
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture on accept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pte_q  <= '0;
            addr_q <= '0;
            acc_q  <= ACC_LOAD;
            user_q <= 1'b0;
            part_q <= 1'b0;
            amr_q  <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            pte_q  <= pte_i;
            addr_q <= pte_addr_i;
            acc_q  <= acc_e'(access_i);
            user_q <= user_i;
            part_q <= part_scope_i;
            amr_q  <= amr_perm_i;
        end
    end

    // Result capture in evaluation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            cause_q <= '0;
            perm_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_EVAL) begin
            fault_q             <= fault_now;
            cause_q             <= '0;
            cause_q[CAUSE_GUARD] <= guard;
            cause_q[CAUSE_PROT]  <= prot;
            perm_q              <= perm_now;
            wdata_q             <= next_pte;
        end
    end

    // Outputs
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_DONE);
        wr_req_o  = (state_q == ST_WRITE);
        wr_addr_o = addr_q;
        wr_data_o = wdata_q;
        fault_o   = fault_q;
        cause_o   = cause_q;
        perm_o    = perm_q;
    end

endmodule

// File: rtl/pte_prot_rc_props.sv
module pte_prot_rc_props
    import pte_prot_pkg::*;
#(
    parameter int unsigned PTE_W  = 64,
    parameter int unsigned ADDR_W = 56
)(
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic              fault_o,
    input logic [1:0]        cause_o,
    input logic [2:0]        perm_o,
    input logic              wr_req_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [PTE_W-1:0]  wr_data_o,
    input logic              wr_ack_i
);

    assert_write_only_granted_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> !fault_o);

    assert_fault_empties_perm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (perm_o == 3'b000));

    assert_single_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_o));

    assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> wr_req_o);

    assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> ($stable(wr_data_o) && $stable(wr_addr_o)));

    assert_ack_to_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_ack_i) |=> done_o);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_reference_marked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> wr_data_o[REF_BIT]);

endmodule

bind pte_prot_rc pte_prot_rc_props #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_o    (done_o),
    .fault_o   (fault_o),
    .cause_o   (cause_o),
    .perm_o    (perm_o),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_ack_i  (wr_ack_i)
);

// File: tb/sim_pte_prot_rc.sv
module sim_pte_prot_rc;

    localparam int CLK_PERIOD = 10;
    localparam int PTE_W  = 64;
    localparam int ADDR_W = 56;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [PTE_W-1:0]  pte_i = '0;
    logic [ADDR_W-1:0] pte_addr_i = '0;
    logic [1:0]        access_i = 2'b00;
    logic              user_i = 1'b0;
    logic              part_scope_i = 1'b0;
    logic [2:0]        amr_perm_i = 3'b000;
    logic              busy_o, done_o, fault_o, wr_req_o;
    logic [1:0]        cause_o;
    logic [2:0]        perm_o;
    logic [ADDR_W-1:0] wr_addr_o;
    logic [PTE_W-1:0]  wr_data_o;
    logic              wr_ack_i = 1'b0;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    int               r_lat;
    int               r_req;
    logic             r_wr;
    logic [PTE_W-1:0] r_wdata;
    logic [ADDR_W-1:0] r_waddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    pte_prot_rc #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pte_i(pte_i),
        .pte_addr_i(pte_addr_i), .access_i(access_i), .user_i(user_i),
        .part_scope_i(part_scope_i), .amr_perm_i(amr_perm_i),
        .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .cause_o(cause_o),
        .perm_o(perm_o), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] pte, input logic [55:0] addr, input logic [1:0] acc,
                       input logic u, input logic p, input logic [2:0] amr, input int ack_wait);
        int wcnt;
        @(negedge clk);
        pte_i = pte; pte_addr_i = addr; access_i = acc;
        user_i = u; part_scope_i = p; amr_perm_i = amr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        r_lat = 0; r_req = 0; r_wr = 1'b0; r_wdata = '0; r_waddr = '0; wcnt = 0;
        while (!done_o && r_lat < 40) begin
            if (wr_req_o) begin
                r_wr = 1'b1; r_req++;
                r_wdata = wr_data_o; r_waddr = wr_addr_o;
                if (wcnt == ack_wait) wr_ack_i = 1'b1;
                wcnt++;
            end
            @(negedge clk);
            wr_ack_i = 1'b0;
            r_lat++;
        end
    endtask

    // Checks outcome of the last run; exp_wr selects the write checks
    task automatic expect_result(input string tag, input logic f, input logic [1:0] c,
                                 input logic [2:0] pm, input logic exp_wr,
                                 input logic [63:0] wd, input logic [55:0] wa, input int lat);
        chk({tag, " fault"}, 64'(fault_o), 64'(f));
        chk({tag, " cause"}, 64'(cause_o), 64'(c));
        chk({tag, " perm"},  64'(perm_o),  64'(pm));
        chk({tag, " wrote"}, 64'(r_wr),    64'(exp_wr));
        chk({tag, " latency"}, 64'(r_lat), 64'(lat));
        if (exp_wr) begin
            chk({tag, " wdata"}, r_wdata, wd);
            chk({tag, " waddr"}, 64'(r_waddr), 64'(wa));
        end
    endtask

    task automatic t_reset;
        chk("R10 reset busy", 64'(busy_o), 64'd0);
        chk("R10 reset done", 64'(done_o), 64'd0);
        chk("R10 reset wr_req", 64'(wr_req_o), 64'd0);
    endtask

    task automatic t_guard;
        // R1: I/O attribute (0x27: attr=10, auth=111) fetched -> guard fault
        run(64'h0000_1234_0000_0027, 56'h00_0000_1000, 2'b10, 1'b0, 1'b0, 3'b111, 0);
        expect_result("R1 guard fetch", 1'b1, 2'b01, 3'b000, 1'b0, '0, '0, 1);
        // R1: same entry loaded -> normal rules, W dropped (R7), ref set (R6)
        run(64'h0000_1234_0000_0027, 56'h00_0000_1008, 2'b00, 1'b0, 1'b0, 3'b111, 0);
        expect_result("R1 guard load", 1'b0, 2'b00, 3'b101, 1'b1,
                      64'h0000_1234_0000_0127, 56'h00_0000_1008, 2);
    endtask

    task automatic t_priv_user;
        // R2: privileged page, user mode, process scope -> protection fault, no write (R12)
        run(64'h0000_0000_0000_000F, 56'h00_0000_2000, 2'b00, 1'b1, 1'b0, 3'b111, 0);
        expect_result("R2 priv user", 1'b1, 2'b10, 3'b000, 1'b0, '0, '0, 1);
    endtask

    task automatic t_auth_only;
        // R3: user page, user mode, mask all-zero ignored
        run(64'hFFFF_0000_0000_0005, 56'h00_0000_3000, 2'b00, 1'b1, 1'b0, 3'b000, 0);
        expect_result("R3 user load", 1'b0, 2'b00, 3'b101, 1'b1,
                      64'hFFFF_0000_0000_0105, 56'h00_0000_3000, 2);
        // R5: store needs write which is absent
        run(64'hFFFF_0000_0000_0005, 56'h00_0000_3000, 2'b01, 1'b1, 1'b0, 3'b111, 0);
        expect_result("R5 store no W", 1'b1, 2'b10, 3'b000, 1'b0, '0, '0, 1);
        // R3: partition scope, privileged page, user mode, store -> allowed, C set (R6)
        run(64'h0000_0000_0000_000F, 56'h00_0000_3010, 2'b01, 1'b1, 1'b1, 3'b000, 0);
        expect_result("R3 partition store", 1'b0, 2'b00, 3'b111, 1'b1,
                      64'h0000_0000_0000_018F, 56'h00_0000_3010, 2);
        // R3: supervisor on privileged page, mask zero ignored; load drops W (R7)
        run(64'h0000_0000_0000_000E, 56'h00_0000_3020, 2'b00, 1'b0, 1'b0, 3'b000, 0);
        expect_result("R3 priv super load", 1'b0, 2'b00, 3'b100, 1'b1,
                      64'h0000_0000_0000_010E, 56'h00_0000_3020, 2);
        // R5: fetch needs execute, absent on that page
        run(64'h0000_0000_0000_000E, 56'h00_0000_3020, 2'b10, 1'b0, 1'b0, 3'b111, 0);
        expect_result("R5 fetch no X", 1'b1, 2'b10, 3'b000, 1'b0, '0, '0, 1);
    endtask

    task automatic t_mask;
        // R4: supervisor, non-privileged, mask 011 -> grant 011; store keeps W (R7)
        run(64'h0000_0000_0000_0007, 56'h00_0000_4000, 2'b01, 1'b0, 1'b0, 3'b011, 0);
        expect_result("R4 mask store", 1'b0, 2'b00, 3'b011, 1'b1,
                      64'h0000_0000_0000_0187, 56'h00_0000_4000, 2);
        // R4: mask 110 removes execute -> fetch faults
        run(64'h0000_0000_0000_0007, 56'h00_0000_4000, 2'b10, 1'b0, 1'b0, 3'b110, 0);
        expect_result("R4 mask fetch", 1'b1, 2'b10, 3'b000, 1'b0, '0, '0, 1);
    endtask

    task automatic t_skip_write;
        // R8: reference already set, load -> no write, done after one edge (R9)
        run(64'h0000_0000_0000_0107, 56'h00_0000_5000, 2'b00, 1'b0, 1'b0, 3'b111, 0);
        expect_result("R8 ref set load", 1'b0, 2'b00, 3'b101, 1'b0, '0, '0, 1);
        // R8: reference and change set, store -> no write
        run(64'h0000_0000_0000_0187, 56'h00_0000_5000, 2'b01, 1'b0, 1'b0, 3'b111, 0);
        expect_result("R8 ref chg store", 1'b0, 2'b00, 3'b111, 1'b0, '0, '0, 1);
    endtask

    task automatic t_slow_ack;
        // R9: reference set, change clear, store -> write; ack after 3 wait cycles
        run(64'h0000_0000_0000_0107, 56'h00_0000_6000, 2'b01, 1'b0, 1'b0, 3'b111, 3);
        expect_result("R9 slow ack", 1'b0, 2'b00, 3'b111, 1'b1,
                      64'h0000_0000_0000_0187, 56'h00_0000_6000, 5);
        chk("R9 req cycles", 64'(r_req), 64'd4);
        // R10: one-cycle done, results held
        @(negedge clk);
        chk("R10 done pulse", 64'(done_o), 64'd0);
        chk("R10 perm held", 64'(perm_o), 64'(3'b111));
    endtask

    task automatic t_reserved_code;
        // R5: code 11 checked as load: read-only page passes
        run(64'h0000_0000_0000_0004, 56'h00_0000_7000, 2'b11, 1'b0, 1'b0, 3'b111, 0);
        expect_result("R5 code 11", 1'b0, 2'b00, 3'b100, 1'b1,
                      64'h0000_0000_0000_0104, 56'h00_0000_7000, 2);
    endtask

    task automatic t_busy_start;
        int lat;
        logic [63:0] seen;
        // R11: start pulse during write is ignored
        @(negedge clk);
        pte_i = 64'h0000_0000_0000_0103; pte_addr_i = 56'h00_0000_8000;
        access_i = 2'b01; user_i = 1'b0; part_scope_i = 1'b0; amr_perm_i = 3'b111;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);   // in write state
        chk("R11 req up", 64'(wr_req_o), 64'd1);
        pte_i = 64'h0000_0000_0000_002F; access_i = 2'b10; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen = wr_data_o;
        wr_ack_i = 1'b1;
        @(negedge clk);
        wr_ack_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk("R11 data kept", seen, 64'h0000_0000_0000_0183);
        chk("R11 done", 64'(done_o), 64'd1);
        chk("R11 fault", 64'(fault_o), 64'd0);
        chk("R11 perm", 64'(perm_o), 64'(3'b011));
        @(negedge clk);
        chk("R11 no second run", 64'(busy_o), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_guard();
        t_priv_user();
        t_auth_only();
        t_mask();
        t_skip_write();
        t_slow_ack();
        t_reserved_code();
        t_busy_start();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule